// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM that has a 16-bit word, a 17-bit word address and one active-low enable per byte lane. The host offers one access at a time with a request, a write flag, an address, write data and a per-byte mask. While the sequencer is free it holds `host_ready` high. Read results come back on `host_rdata` with a one-cycle `host_rvalid` strobe.

On the memory side the sequencer drives active-low chip select, read strobe, write strobe and lane enables, plus the write data with a separate drive-enable bit for each byte lane. The memory's timing minimums are given in picoseconds together with the clock period. The sequencer turns each one into a cycle count, rounded up. Those counts are the access window, the lane release time after the write strobe falls, the data setup and the write pulse. The power-up delay is converted the same way.

The read strobe stays high for the whole write, and write data is driven only after the memory has had time to release the bus. At least one deselected cycle separates any two accesses. All memory-side controls come from registers.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `host_ready` stays low and `mem_ce_n` stays high for PWR_CYC = ceil(T_PWR_PS/TCLK_PS) cycles. `host_ready` first reads high in the PWR_CYC-th cycle after reset is released.
- R2: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for exactly ACC_CYC = max(1, ceil(T_ACC_PS/TCLK_PS)) cycles. The bus is sampled in the last of those cycles. `host_rvalid` is high for one cycle, ACC_CYC+1 cycles after the accepting edge.
- R3: During an access, `mem_be_n[i]` is low exactly when `host_mask[i]` was set at acceptance. Lane 0 is bits 7:0 and lane 1 is bits 15:8. While `mem_ce_n` is high, every `mem_be_n` bit is high.
- R4: A read returns zero in each byte lane whose mask bit is clear, and the memory word in each lane whose mask bit is set.
- R5: A write keeps `mem_oe_n` high throughout and holds `mem_we_n` low for TURN_CYC + DATA_CYC cycles. TURN_CYC = max(1, ceil(T_REL_PS/TCLK_PS)). DATA_CYC = max(1, ceil(T_SU_PS/TCLK_PS), ceil(T_WP_PS/TCLK_PS) - TURN_CYC). No data is driven in the first TURN_CYC cycles. Data is driven during the last DATA_CYC cycles and up to the cycle in which `mem_we_n` rises.
- R6: `mem_dq_oe[i]` is high only while `mem_ce_n` and `mem_we_n` are low, `mem_oe_n` is high and lane i is enabled. The sequencer never drives the bus while the memory may drive it.
- R7: Every access begins after at least one cycle with `mem_ce_n` high. `host_ready` is high only when no access is in progress.
- R8: The address, data, mask and direction are captured at the accepting edge, so host inputs may change afterwards. A request made while `host_ready` is low starts no access and writes nothing.
- R9: A write with an all-clear mask still runs the full strobe sequence but drives no lane and leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, taken when `host_ready` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_mask | input | DATA_W/8 | Byte-lane select, bit i = bits 8i+7:8i |
| host_ready | output | 1 | Sequencer idle and able to accept |
| host_rdata | output | DATA_W | Read result, disabled lanes zero |
| host_rvalid | output | 1 | One-cycle strobe for `host_rdata` |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_dq_o | output | DATA_W | Write data toward the bus |
| mem_dq_oe | output | DATA_W/8 | Per-lane drive enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W | Data returned from the bus |

## Verification
The bench's memory model returns a poison word until the read strobe has been low for the full access window. A sequencer that samples one cycle early therefore returns poison instead of the stored word. Masked writes and reads cover each lane alone, both lanes and neither lane. A lane-enable or zero-fill error shows up as a wrong byte on read-back. The bench counts strobe widths, drive cycles and latency against the rounded-up formulas, so an off-by-one in any phase length is reported. It also changes host inputs after acceptance and issues stray requests both during power-up and during an access. A sequencer that does not latch its inputs, or that obeys a request while busy, corrupts memory or adds an access that the bench counts.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP = 3'd0,
      ST_IDLE  = 3'd1,
      ST_READ  = 3'd2,
      ST_WREL  = 3'd3,
      ST_WDAT  = 3'd4,
      ST_GAP   = 3'd5
   } phase_e;

   // ceiling division for picosecond-to-cycle conversion
   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int atleast1(input int v);
      return (v < 1) ? 1 : v;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_req_latch.sv
module asram_req_latch #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [LANES-1:0]  in_mask,
   output logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_data,
   output logic [LANES-1:0]  q_mask
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_addr <= '0;
         q_data <= '0;
         q_mask <= '0;
      end else if (take) begin
         q_addr <= in_addr;
         q_data <= in_data;
         q_mask <= in_mask;
      end
   end

endmodule

// File: rtl/asram_phase_seq.sv
module asram_phase_seq
   import asram_pkg::*;
#(
   parameter int ACC_CYC  = 1,
   parameter int TURN_CYC = 1,
   parameter int DATA_CYC = 1,
   parameter int PWR_CYC  = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   host_req,
   input  logic   host_we,
   output logic   ready,
   output logic   accept,
   output logic   cap,
   output phase_e phase_d
);

   localparam int MAXC = imax(imax(ACC_CYC, TURN_CYC), imax(DATA_CYC, PWR_CYC));
   localparam int CW   = imax(1, $clog2(MAXC + 1));

   if (ACC_CYC < 1 || TURN_CYC < 1 || DATA_CYC < 1 || PWR_CYC < 1) begin : g_bad_cyc
      $error("asram_phase_seq: every phase needs at least one cycle");
   end

   phase_e          phase_q;
   logic [CW-1:0]   cnt_q, cnt_d;
   logic            last;

   assign last   = (cnt_q == '0);
   assign ready  = (phase_q == ST_IDLE);
   assign accept = ready && host_req;
   assign cap    = (phase_q == ST_READ) && last;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = last ? cnt_q : cnt_q - CW'(1);
      unique case (phase_q)
         ST_PWRUP: if (last) phase_d = ST_IDLE;
         ST_IDLE: begin
            if (host_req) begin
               if (host_we) begin
                  phase_d = ST_WREL;
                  cnt_d   = CW'(TURN_CYC - 1);
               end else begin
                  phase_d = ST_READ;
                  cnt_d   = CW'(ACC_CYC - 1);
               end
            end
         end
         ST_READ: if (last) phase_d = ST_GAP;
         ST_WREL: begin
            if (last) begin
               phase_d = ST_WDAT;
               cnt_d   = CW'(DATA_CYC - 1);
            end
         end
         ST_WDAT: if (last) phase_d = ST_GAP;
         ST_GAP:  phase_d = ST_IDLE;
         default: phase_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= ST_PWRUP;
         cnt_q   <= CW'(PWR_CYC - 1);
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   // R7: the only way into an access is from the idle phase
   p_entry_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == ST_READ || phase_q == ST_WREL) && $changed(phase_q)
         |-> $past(phase_q) == ST_IDLE);

   // R5: the write strobe phases always run in order
   p_wdat_after_wrel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_q == ST_WDAT) |-> $past(phase_q) == ST_WREL);

endmodule

// File: rtl/asram_lane.sv
module asram_lane #(
   parameter bit ZERO_UNSEL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_d,
   input  logic       drv_d,
   input  logic       en_d,
   input  logic       en_q,
   input  logic       cap,
   input  logic [7:0] din,
   output logic       be_n,
   output logic       dq_oe,
   output logic [7:0] rbyte
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         be_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         be_n  <= !(acc_d && en_d);
         dq_oe <= drv_d && en_d;
      end
   end

   if (ZERO_UNSEL) begin : g_zero_fill
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   rbyte <= '0;
         else if (cap) rbyte <= en_q ? din : 8'h00;
      end
   end else begin : g_keep_stale
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           rbyte <= '0;
         else if (cap && en_q) rbyte <= din;
      end
   end

   // R6: a lane is driven only while its enable is asserted
   p_lane_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !be_n);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 16,
   parameter int TCLK_PS    = 20000,
   parameter int T_ACC_PS   = 10000,
   parameter int T_WP_PS    = 7000,
   parameter int T_SU_PS    = 5000,
   parameter int T_REL_PS   = 5000,
   parameter int T_PWR_PS   = 100_000_000,
   parameter bit ZERO_UNSEL = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   host_req,
   input  logic                   host_we,
   input  logic [ADDR_W-1:0]      host_addr,
   input  logic [DATA_W-1:0]      host_wdata,
   input  logic [DATA_W/8-1:0]    host_mask,
   output logic                   host_ready,
   output logic [DATA_W-1:0]      host_rdata,
   output logic                   host_rvalid,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   mem_ce_n,
   output logic                   mem_oe_n,
   output logic                   mem_we_n,
   output logic [DATA_W/8-1:0]    mem_be_n,
   output logic [DATA_W-1:0]      mem_dq_o,
   output logic [DATA_W/8-1:0]    mem_dq_oe,
   input  logic [DATA_W-1:0]      mem_dq_i
);

   localparam int LANES    = DATA_W / 8;
   localparam int ACC_CYC  = atleast1(cdiv(T_ACC_PS, TCLK_PS));
   localparam int TURN_CYC = atleast1(cdiv(T_REL_PS, TCLK_PS));
   localparam int SU_CYC   = cdiv(T_SU_PS, TCLK_PS);
   localparam int WP_CYC   = cdiv(T_WP_PS, TCLK_PS);
   localparam int DATA_CYC = atleast1(imax(SU_CYC, WP_CYC - TURN_CYC));
   localparam int PWR_CYC  = atleast1(cdiv(T_PWR_PS, TCLK_PS));

   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_width
      $error("asram_ctrl: DATA_W must be a non-zero multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("asram_ctrl: ADDR_W must be positive");
   end
   if (TCLK_PS < 1 || T_ACC_PS < 0 || T_WP_PS < 0 || T_SU_PS < 0 ||
       T_REL_PS < 0 || T_PWR_PS < 0) begin : g_bad_time
      $error("asram_ctrl: timing parameters out of range");
   end

   phase_e           phase_d;
   logic             accept, cap;
   logic             acc_d, wr_d, drv_d;
   logic [LANES-1:0] lat_mask, mask_d;
   logic [DATA_W-1:0] lat_data;

   asram_phase_seq #(
      .ACC_CYC  (ACC_CYC),
      .TURN_CYC (TURN_CYC),
      .DATA_CYC (DATA_CYC),
      .PWR_CYC  (PWR_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_req (host_req),
      .host_we  (host_we),
      .ready    (host_ready),
      .accept   (accept),
      .cap      (cap),
      .phase_d  (phase_d)
   );

   asram_req_latch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (accept),
      .in_addr (host_addr),
      .in_data (host_wdata),
      .in_mask (host_mask),
      .q_addr  (mem_addr),
      .q_data  (lat_data),
      .q_mask  (lat_mask)
   );

   assign mem_dq_o = lat_data;
   assign acc_d    = (phase_d == ST_READ) || (phase_d == ST_WREL) || (phase_d == ST_WDAT);
   assign wr_d     = (phase_d == ST_WREL) || (phase_d == ST_WDAT);
   assign drv_d    = (phase_d == ST_WDAT);
   assign mask_d   = accept ? host_mask : lat_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ce_n    <= 1'b1;
         mem_we_n    <= 1'b1;
         mem_oe_n    <= 1'b1;
         host_rvalid <= 1'b0;
      end else begin
         mem_ce_n    <= !acc_d;
         mem_we_n    <= !wr_d;
         mem_oe_n    <= !(phase_d == ST_READ);
         host_rvalid <= cap;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      asram_lane #(
         .ZERO_UNSEL (ZERO_UNSEL)
      ) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .acc_d (acc_d),
         .drv_d (drv_d),
         .en_d  (mask_d[i]),
         .en_q  (lat_mask[i]),
         .cap   (cap),
         .din   (mem_dq_i[8*i +: 8]),
         .be_n  (mem_be_n[i]),
         .dq_oe (mem_dq_oe[i]),
         .rbyte (host_rdata[8*i +: 8])
      );
   end

   // ---------------- assertions ----------------
   logic up_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          up_seen <= 1'b0;
      else if (host_ready) up_seen <= 1'b1;
   end

   p_no_access_pwrup_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !up_seen && !host_ready |-> mem_ce_n);

   p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(!mem_oe_n) && mem_oe_n);

   p_rvalid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |=> !host_rvalid);

   p_lanes_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (&mem_be_n));

   p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   p_no_drive_at_wstart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> (mem_dq_oe == '0));

   p_drive_only_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|mem_dq_oe) |-> (!mem_we_n && !mem_ce_n && mem_oe_n));

   p_gap_before_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> $past(mem_ce_n));

   p_gap_before_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(mem_ce_n));

   p_ready_means_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> mem_ce_n);

endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;

   // timing used by this bench: 4 ns assumed period for cycle conversion
   localparam int AW   = 17;
   localparam int DW   = 16;
   localparam int ACC  = 3;   // ceil(10000/4000)
   localparam int TURN = 2;   // ceil(5000/4000)
   localparam int DCY  = 2;   // max(1, ceil(5000/4000), ceil(7000/4000)-2)
   localparam int PWR  = 100; // ceil(400000/4000)

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_req = 1'b0;
   logic          host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [1:0]    host_mask = '0;
   logic          host_ready, host_rvalid;
   logic [DW-1:0] host_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n;
   logic [1:0]    mem_be_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_o, mem_dq_i;

   always #10 clk = ~clk;  // 50 MHz

   asram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .TCLK_PS(4000), .T_ACC_PS(10000),
      .T_WP_PS(7000), .T_SU_PS(5000), .T_REL_PS(5000), .T_PWR_PS(400_000),
      .ZERO_UNSEL(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
      .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] dflt(input logic [AW-1:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   // ---------------- memory model (1024 words, aliased on low address bits) ----------------
   logic [15:0] mdl [1024];
   logic [15:0] shadow [1024];
   int          rd_cnt = 0;
   logic        reading;
   logic [15:0] mw;

   assign reading  = !mem_ce_n && !mem_oe_n && mem_we_n;
   assign mw       = mdl[mem_addr[9:0]];
   assign mem_dq_i = (reading && rd_cnt >= ACC - 1)
                     ? {mem_be_n[1] ? 8'hEE : mw[15:8], mem_be_n[0] ? 8'hEE : mw[7:0]}
                     : 16'hBAAD;

   always @(posedge clk) begin
      rd_cnt <= reading ? rd_cnt + 1 : 0;
      if (!mem_ce_n && !mem_we_n) begin
         if (!mem_be_n[0] && mem_dq_oe[0]) mdl[mem_addr[9:0]][7:0]  <= mem_dq_o[7:0];
         if (!mem_be_n[1] && mem_dq_oe[1]) mdl[mem_addr[9:0]][15:8] <= mem_dq_o[15:8];
      end
   end

   // access counter and contention monitor
   int   n_acc = 0;
   logic prev_ce = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_ce && !mem_ce_n) n_acc++;
         if ((|mem_dq_oe) && !mem_oe_n)
            chk(1'b0, "R6", "bus driven while read strobe low", mem_dq_oe, 0);
      end
      prev_ce = mem_ce_n;
   end

   // ---------------- scoreboard ----------------
   logic [15:0] exp_q [$];
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected rvalid", 1, 0);
         else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(host_rdata == e, "R2/R4", "read data", host_rdata, e);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic access(input bit we, input logic [AW-1:0] a, input logic [15:0] d,
                         input logic [1:0] m, input bit stray);
      int n = 0, ce_lo = 0, we_lo = 0, oe_lo = 0, drv = 0, rv_at = 0;
      int be_bad = 0, oe_in_wr = 0, early_drv = 0, acc0;
      while (!host_ready) @(negedge clk);
      acc0 = n_acc;
      host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_mask = m;
      if (!we) begin
         logic [15:0] s;
         s = shadow[a[9:0]];
         exp_q.push_back({m[1] ? s[15:8] : 8'h00, m[0] ? s[7:0] : 8'h00});
      end else begin
         if (m[0]) shadow[a[9:0]][7:0]  = d[7:0];
         if (m[1]) shadow[a[9:0]][15:8] = d[15:8];
      end
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) begin  // R8: inputs scrambled after acceptance
            host_req = 1'b0; host_addr = ~a; host_wdata = ~d; host_mask = ~m; host_we = ~we;
         end
         if (stray && n == 2) begin
            host_req = 1'b1; host_we = 1'b1; host_addr = 17'h003C5;
            host_wdata = 16'hDEAD; host_mask = 2'b11;
         end
         if (stray && n == 3) host_req = 1'b0;
         if (host_ready || n > 40) break;
         if (!mem_ce_n) begin
            ce_lo++;
            if (mem_be_n != ~m) be_bad++;
            if (mem_addr != a) be_bad++;
         end
         if (!mem_we_n) begin
            we_lo++;
            if (!mem_oe_n) oe_in_wr++;
            if (we_lo <= TURN && (|mem_dq_oe)) early_drv++;
         end
         if (|mem_dq_oe) begin
            drv++;
            if (mem_dq_oe != m) be_bad++;
         end
         if (!mem_oe_n) oe_lo++;
         if (host_rvalid && rv_at == 0) rv_at = n;
      end
      chk(be_bad == 0, "R3", "lane enables/address during access", be_bad, 0);
      chk(n_acc == acc0 + 1, "R8", "accesses started", n_acc - acc0, 1);
      if (!we) begin
         chk(ce_lo == ACC && oe_lo == ACC, "R2", "read strobe cycles", oe_lo, ACC);
         chk(rv_at == ACC + 1, "R2", "rvalid latency", rv_at, ACC + 1);
      end else begin
         chk(we_lo == TURN + DCY, "R5", "write strobe cycles", we_lo, TURN + DCY);
         chk(oe_in_wr == 0, "R5", "read strobe low in write", oe_in_wr, 0);
         chk(early_drv == 0, "R5", "data driven before release", early_drv, 0);
         chk(drv == ((m == 2'b00) ? 0 : DCY), (m == 2'b00) ? "R9" : "R5",
             "data drive cycles", drv, (m == 2'b00) ? 0 : DCY);
      end
      chk(mem_ce_n, "R7", "deselect after access", mem_ce_n, 1);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int pw;
      for (int i = 0; i < 1024; i++) begin
         mdl[i] = dflt(AW'(i));
         shadow[i] = dflt(AW'(i));
      end
      repeat (3) @(negedge clk);
      chk(!host_ready && mem_ce_n && mem_we_n && mem_oe_n, "R1", "reset outputs",
          {host_ready, mem_ce_n, mem_we_n, mem_oe_n}, 4'b0111);
      chk(mem_be_n == 2'b11 && mem_dq_oe == 2'b00 && !host_rvalid, "R3", "reset lanes",
          {mem_be_n, mem_dq_oe}, 4'b1100);
      rst_n = 1'b1;
      pw = 0;
      do begin
         @(negedge clk);
         pw++;
         if (pw == 10) begin host_req = 1'b1; host_we = 1'b1; host_mask = 2'b11; end
         if (pw == 20) host_req = 1'b0;
      end while (!host_ready && pw < 1000);
      chk(pw == PWR, "R1", "power-up cycles", pw, PWR);
      chk(n_acc == 0, "R1", "accesses during power-up", n_acc, 0);
      chk(mdl[0] == dflt(0), "R8", "memory untouched during power-up", mdl[0], dflt(0));

      access(1'b1, 17'h00010, 16'h1234, 2'b11, 1'b0);
      access(1'b0, 17'h00010, 16'h0000, 2'b11, 1'b0);
      access(1'b1, 17'h1FFFF, 16'hABCD, 2'b01, 1'b0);   // lower lane only
      access(1'b0, 17'h1FFFF, 16'h0000, 2'b11, 1'b0);
      access(1'b0, 17'h1FFFF, 16'h0000, 2'b10, 1'b0);   // R4: lower zeroed
      access(1'b0, 17'h00010, 16'h0000, 2'b01, 1'b0);   // R4: upper zeroed
      access(1'b1, 17'h00123, 16'h7E81, 2'b10, 1'b0);   // upper lane only
      access(1'b0, 17'h00123, 16'h0000, 2'b11, 1'b0);
      access(1'b1, 17'h00200, 16'hFFFF, 2'b00, 1'b0);   // R9: no lane
      access(1'b0, 17'h00200, 16'h0000, 2'b11, 1'b0);
      access(1'b0, 17'h00050, 16'h0000, 2'b11, 1'b1);   // R8: stray request while busy
      access(1'b0, 17'h003C5, 16'h0000, 2'b11, 1'b0);
      for (int i = 0; i < 24; i++) begin
         logic [AW-1:0] a;
         a = AW'((i * 37 + 5) % 64 + 17'h00300);
         access(i[0], a, 16'(i * 16'h1F3B + 16'h0421), 2'(i % 4), 1'b0);
         access(1'b0, a, 16'h0000, 2'(3 - i % 4), 1'b0);
      end
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2", "reads outstanding", exp_q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule